// File: doc/BRIEF.md
# Five-Channel Reload Timer Bank

The block holds five independent down-counters that share one control word. Each counter steps down by one on a tick strobe supplied per channel by an external tick generator. Software reaches the block through a word-addressed register port. A write takes effect on the clock edge on which `wr_en` is sampled high. Read data is a combinational function of `addr`. Every channel has a count buffer. Channels 0 to 3 also have a compare buffer that is stored and read back only. The counter takes a value from its count buffer in only two cases: a manual-update bit that goes from 0 to 1 in a control write, or an automatic reload on expiry.

Control bits act on transitions between the stored control word and the newly written one. A start bit that rises starts the channel, and a start bit that falls stops it. A channel expires when a tick arrives while its counter is zero. It then drives a one-cycle pulse on its `expire` line and, depending on its auto-reload bit, either reloads and keeps running or stops. When it stops, hardware clears its start bit. The live count of every channel can be read back.

The register port carries single-word accesses with no back-pressure. A write is accepted on every cycle in which `wr_en` is high, and `rdata` is valid in the same cycle as `addr`. The port therefore has no ready signal, and the block never stalls an access.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads zero, every counter is zero, every channel is stopped and no `expire` line is high.
- R2: In the control word (word 2), channel x has a field base of 0 for x=0 and 4+4x for x≥1. Within the field, offset 0 is start, offset 1 is manual update and offset 2 is output invert; channel 4 has no invert bit. Auto-reload sits at offset 3 for channels 0 to 3 and at bit 22 for channel 4. Writing all ones reads back 0x007FFF0F, so bits 4 to 7 and bits 23 and above read zero.
- R3: A control write that raises a channel's manual-update bit from 0 to 1 loads that channel's count buffer into its counter on the write edge. Writing the bit while it is already 1 loads nothing.
- R4: While a channel's start bit is 1, each tick on that channel decrements a non-zero count by exactly one. While the bit is 0, ticks leave the count unchanged.
- R5: A control write that drops a start bit from 1 to 0 stops the channel and holds its count.
- R6: A tick on a running channel whose count is zero raises `expire[x]` for exactly the one following cycle. If auto-reload is set, the counter reloads from its count buffer and keeps running, so a channel loaded with N expires once every N+1 ticks.
- R7: On expiry with auto-reload clear, the counter stays at zero and hardware clears the channel's start bit. Later ticks produce no pulse.
- R8: Word addresses (word = byte offset / 4) are as follows. For x<4: count buffer 3+3x, compare buffer 4+3x, count readback 5+3x. For channel 4: count buffer 15, count readback 16, and no compare buffer. Configuration words sit at 0 and 1. Buffers hold 16 bits and read back zero-extended.
- R9: A count-readback word returns the live counter value. Writes to it are ignored.
- R10: Words 17 to 31 read zero, and writes to them change no register.
- R11: The two configuration words store and read back all 32 written bits.
- R12: When a manual-update rising edge and a tick reach the same channel in the same cycle, the load wins and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 5 | Per-channel count strobe from the tick generator |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 5 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| expire | output | 5 | One-cycle expiry pulse per channel |

## Verification
The hardest situation to reach from the ports is a control write with a manual-update rising edge that lands on the same edge as a tick on a zero-count running channel. The bench drives the write and the tick in the same cycle and checks that the load takes precedence. The one-shot stop is a second hard case, because the start bit changes without any software write. The bench reaches it by running each channel to zero with auto-reload clear and then reading the control word back. A sweep over every channel and several reload values compares every readback and pulse against N-(k mod (N+1)).

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH     = 5;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int CTRL_W  = 23;
  localparam int CFG0_A  = 0;
  localparam int CFG1_A  = 1;
  localparam int CTRL_A  = 2;
  localparam int LAST_A  = 16;

  function automatic int fld_base(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int start_pos(input int ch);
    return fld_base(ch);
  endfunction

  function automatic int mupd_pos(input int ch);
    return fld_base(ch) + 1;
  endfunction

  function automatic int arl_pos(input int ch);
    return (ch == NCH - 1) ? 22 : fld_base(ch) + 3;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[start_pos(c)] = 1'b1;
      m[mupd_pos(c)]  = 1'b1;
      m[arl_pos(c)]   = 1'b1;
      if (c < NCH - 1) m[fld_base(c) + 2] = 1'b1;
    end
    return m;
  endfunction

  function automatic int cntb_addr(input int ch);
    return (ch < NCH - 1) ? 3 + 3 * ch : 15;
  endfunction

  function automatic int cmpb_addr(input int ch);
    return 4 + 3 * ch;
  endfunction

  function automatic int cnto_addr(input int ch);
    return (ch < NCH - 1) ? 5 + 3 * ch : 16;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             arl,
  input  logic             load,
  input  logic [CNT_W-1:0] buf_val,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             stop_req
);
  logic at_zero;
  logic step;

  assign at_zero  = (count == '0);
  assign step     = run && tick && !load;
  assign stop_req = step && at_zero && !arl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        count <= buf_val;
      end else if (step) begin
        if (at_zero) begin
          expire <= 1'b1;
          if (arl) count <= buf_val;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  // R3: a manual-update load lands on the next edge
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(buf_val)));

  // R4: a stopped channel with no load holds its count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));

  // R6: reload on expiry with auto-reload set
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && arl) |=> (expire && count == $past(buf_val)));

  // R12: a load never produces a pulse
  a_r12_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (load || !run) |=> !expire);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NCH-1:0]             stop_req,
  output logic [DATA_W-1:0]          cfg0,
  output logic [DATA_W-1:0]          cfg1,
  output logic [CTRL_W-1:0]          ctrl,
  output logic [NCH-1:0][CNT_W-1:0]  cnt_buf,
  output logic [NCH-2:0][CNT_W-1:0]  cmp_buf,
  output logic [NCH-1:0]             run,
  output logic [NCH-1:0]             arl,
  output logic [NCH-1:0]             load
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask();

  logic              wr_ctrl;
  logic [CTRL_W-1:0] clr;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_A));

  always_comb begin
    clr = '0;
    for (int c = 0; c < NCH; c++) clr[start_pos(c)] = stop_req[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cfg0 <= '0;
      cfg1 <= '0;
    end else begin
      if (wr_ctrl) ctrl <= wdata[CTRL_W-1:0] & MASK;
      else         ctrl <= ctrl & ~clr;
      if (wr_en && addr == ADDR_W'(CFG0_A)) cfg0 <= wdata;
      if (wr_en && addr == ADDR_W'(CFG1_A)) cfg1 <= wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int SP = start_pos(c);
    localparam int MP = mupd_pos(c);
    localparam int AP = arl_pos(c);

    assign run[c]  = ctrl[SP];
    assign arl[c]  = ctrl[AP];
    assign load[c] = wr_ctrl && wdata[MP] && !ctrl[MP];

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_buf[c] <= '0;
      else if (wr_en && addr == ADDR_W'(cntb_addr(c))) cnt_buf[c] <= wdata[CNT_W-1:0];
    end

    // R7: hardware stop clears the start bit when software is silent
    a_r7_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req[c] && !wr_ctrl) |=> !ctrl[SP]);
  end

  for (genvar c = 0; c < NCH - 1; c++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) cmp_buf[c] <= '0;
      else if (wr_en && addr == ADDR_W'(cmpb_addr(c))) cmp_buf[c] <= wdata[CNT_W-1:0];
    end
  end

  // R2: unimplemented control bits never become set
  a_r2_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl & ~MASK) == '0);

  // R5: a start bit only rises through a control write
  a_r5_start_src: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ((ctrl & ~$past(ctrl)) == '0));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          cfg0,
  input  logic [DATA_W-1:0]          cfg1,
  input  logic [CTRL_W-1:0]          ctrl,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_buf,
  input  logic [NCH-2:0][CNT_W-1:0]  cmp_buf,
  input  logic [NCH-1:0][CNT_W-1:0]  count,
  output logic [DATA_W-1:0]          rdata
);
  localparam int PAD = DATA_W - CNT_W;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CFG0_A)) rdata = cfg0;
    if (addr == ADDR_W'(CFG1_A)) rdata = cfg1;
    if (addr == ADDR_W'(CTRL_A)) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(cntb_addr(c))) rdata = {{PAD{1'b0}}, cnt_buf[c]};
      if (addr == ADDR_W'(cnto_addr(c))) rdata = {{PAD{1'b0}}, count[c]};
    end
    for (int c = 0; c < NCH - 1; c++) begin
      if (addr == ADDR_W'(cmpb_addr(c))) rdata = {{PAD{1'b0}}, cmp_buf[c]};
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    expire
);
  logic [DATA_W-1:0]         cfg0, cfg1;
  logic [CTRL_W-1:0]         ctrl;
  logic [NCH-1:0][CNT_W-1:0] cnt_buf;
  logic [NCH-2:0][CNT_W-1:0] cmp_buf;
  logic [NCH-1:0][CNT_W-1:0] count;
  logic [NCH-1:0]            run, arl, load, stop_req;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stop_req(stop_req), .cfg0(cfg0), .cfg1(cfg1), .ctrl(ctrl),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .run(run), .arl(arl), .load(load)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick[c]), .run(run[c]), .arl(arl[c]),
      .load(load[c]), .buf_val(cnt_buf[c]), .count(count[c]),
      .expire(expire[c]), .stop_req(stop_req[c])
    );
  end

  tmr_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .addr(addr), .cfg0(cfg0), .cfg1(cfg1), .ctrl(ctrl), .cnt_buf(cnt_buf),
    .cmp_buf(cmp_buf), .count(count), .rdata(rdata)
  );

  // R10: words past the map never return data
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > ADDR_W'(LAST_A)) |-> (rdata == '0));
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  expire;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tmr_bank dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .expire(expire));

  always #10 clk = ~clk;

  function automatic int base(int ch); return ch == 0 ? 0 : 4 + 4 * ch; endfunction
  function automatic logic [31:0] b_st(int ch); return 32'd1 << base(ch); endfunction
  function automatic logic [31:0] b_mu(int ch); return 32'd1 << (base(ch) + 1); endfunction
  function automatic logic [31:0] b_ar(int ch); return 32'd1 << (ch == 4 ? 22 : base(ch) + 3); endfunction
  function automatic logic [4:0] a_cntb(int ch); return ch < 4 ? 5'(3 + 3 * ch) : 5'd15; endfunction
  function automatic logic [4:0] a_cmpb(int ch); return 5'(4 + 3 * ch); endfunction
  function automatic logic [4:0] a_cnto(int ch); return ch < 4 ? 5'(5 + 3 * ch) : 5'd16; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(int ch);
    @(negedge clk);
    tick = 5'd1 << ch;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10: everything reads zero after reset
    for (int a = 0; a < 32; a++) rd("R1 reset read", 5'(a), 32'h0);
    chk("R1 expire idle", {27'h0, expire}, 32'h0);

    // R11
    wr(5'd0, 32'hA5C3_1234); wr(5'd1, 32'hFFFF_0001);
    rd("R11 cfg0", 5'd0, 32'hA5C3_1234);
    rd("R11 cfg1", 5'd1, 32'hFFFF_0001);

    // R2
    wr(5'd2, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 5'd2, 32'h007F_FF0F);
    wr(5'd2, 32'h0);
    rd("R2 ctrl clear", 5'd2, 32'h0);

    // R8 / R9 / R10
    for (int c = 0; c < 5; c++) begin
      wr(a_cntb(c), 32'hABCD_0000 | 32'(c * 17 + 3));
      if (c < 4) wr(a_cmpb(c), 32'h1234_0000 | 32'(c * 9 + 200));
      wr(a_cnto(c), 32'h0000_7777);
    end
    for (int a = 17; a < 32; a++) wr(5'(a), 32'hFFFF_FFFF);
    for (int c = 0; c < 5; c++) begin
      rd("R8 count buffer", a_cntb(c), 32'(c * 17 + 3));
      if (c < 4) rd("R8 compare buffer", a_cmpb(c), 32'(c * 9 + 200));
      rd("R9 readback write ignored", a_cnto(c), 32'h0);
    end
    for (int a = 17; a < 32; a++) rd("R10 undefined", 5'(a), 32'h0);
    rd("R10 ctrl untouched", 5'd2, 32'h0);
    rd("R10 cfg0 untouched", 5'd0, 32'hA5C3_1234);

    // R4 / R6 sweep: auto-reload on every channel
    for (int c = 0; c < 5; c++) begin
      int nv [4] = '{0, 1, 2, 5};
      for (int i = 0; i < 4; i++) begin
        int n = nv[i];
        wr(a_cntb(c), 32'(n));
        wr(5'd2, b_mu(c) | b_ar(c));
        rd("R3 load", a_cnto(c), 32'(n));
        pulse(c);
        rd("R4 stopped hold", a_cnto(c), 32'(n));
        wr(5'd2, b_st(c) | b_ar(c));
        for (int k = 1; k <= 2 * (n + 1) + 1; k++) begin
          pulse(c);
          chk("R6 expire pulse", {27'h0, expire},
              (k % (n + 1) == 0) ? (32'd1 << c) : 32'd0);
          rd("R4 live count", a_cnto(c), 32'(n - (k % (n + 1))));
        end
        @(negedge clk);
        chk("R6 pulse one cycle", {27'h0, expire}, 32'h0);
        rd("R6 still running", 5'd2, b_st(c) | b_ar(c));
        wr(5'd2, 32'h0);
        pulse(c);
        rd("R5 stop holds", a_cnto(c), 32'(n - ((2 * (n + 1) + 1) % (n + 1))));
      end
    end

    // R7 one-shot on every channel
    for (int c = 0; c < 5; c++) begin
      wr(a_cntb(c), 32'd2);
      wr(5'd2, b_mu(c));
      wr(5'd2, b_st(c));
      pulse(c); pulse(c);
      rd("R7 counted to zero", a_cnto(c), 32'h0);
      pulse(c);
      chk("R7 expire", {27'h0, expire}, 32'd1 << c);
      rd("R7 start cleared", 5'd2, 32'h0);
      pulse(c);
      chk("R7 no second pulse", {27'h0, expire}, 32'h0);
      rd("R7 stays zero", a_cnto(c), 32'h0);
    end

    // R3 level held, R12 collision on channel 0
    wr(a_cntb(0), 32'd3);
    wr(5'd2, b_mu(0) | b_st(0));
    pulse(0);
    rd("R4 decrement", a_cnto(0), 32'd2);
    wr(5'd2, b_mu(0) | b_st(0));
    rd("R3 held bit no reload", a_cnto(0), 32'd2);
    wr(5'd2, b_st(0));
    pulse(0); pulse(0);
    rd("R12 at zero", a_cnto(0), 32'd0);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'd2; wdata = b_mu(0) | b_st(0); tick = 5'd1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; tick = '0;
    chk("R12 no pulse", {27'h0, expire}, 32'h0);
    rd("R12 load wins", a_cnto(0), 32'd3);
    rd("R12 still running", 5'd2, b_mu(0) | b_st(0));

    finish_run();
  end
endmodule